// File: doc/BRIEF.md
# Byte-Cell Memory with Word Access

This block is a single-port store made of 8-bit cells. A request can move one byte to or from one cell. It can also move a 16-bit word through two neighbouring cells. Bits inside a cell cannot be addressed on their own, so every write replaces a whole cell.

For a word, a select input picks the byte order. In little-endian order the low byte sits at the request address A and the high byte at A+1. In big-endian order the high byte sits at A and the low byte at A+1. A byte access completes in one clock cycle. A word access uses one cycle per cell, so it takes two cycles. A one-cycle `done` pulse marks the end of every access. When the address is the last cell, the second byte of a word wraps to cell 0.

The address width is a parameter. At 16 bits the store holds 65536 cells (64 KB). The default is kept small so that elaboration stays light. Cell contents after power-up are undefined, and a cell keeps its value until it is written again.

Top module: `byte_cell_mem`

## Requirements
- R1: A byte write stores `wdata[7:0]` in cell `addr`. A later byte read of that cell returns the value on `rdata[7:0]`, with `rdata[15:8]` equal to 0. `big_end` has no effect on a byte access.
- R2: A write changes only the cell or cells it addresses. Every other cell keeps its earlier contents.
- R3: A word write with `big_end`=0 stores `wdata[7:0]` at A and `wdata[15:8]` at A+1 (for example, 0F23h at A gives 23h at A and 0Fh at A+1).
- R4: A word write with `big_end`=1 stores `wdata[15:8]` at A and `wdata[7:0]` at A+1.
- R5: A word read assembles `rdata` with the same byte order as a word write: with `big_end`=0 the cell at A is the low byte, and with `big_end`=1 it is the high byte.
- R6: A byte access raises `done` in the cycle after the accepting edge, and `busy` stays low. A word access raises `busy` for exactly one cycle after the accepting edge, then raises `done` for one cycle with `busy` low.
- R7: A word access at the highest address places its second byte in cell 0.
- R8: A request presented while `busy` is high is ignored. It writes nothing and does not lengthen the current access.
- R9: After reset, `done`, `busy` and `rdata` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | 1 | Start an access (taken when `busy` is low) |
| we | input | 1 | 1 = write, 0 = read |
| word | input | 1 | 1 = 16-bit word access, 0 = byte access |
| big_end | input | 1 | Word byte order: 1 = high byte at A, 0 = low byte at A |
| addr | input | ADDR_W | Cell address A |
| wdata | input | 16 | Write data (byte access uses bits 7:0) |
| rdata | output | 16 | Read data, valid while `done` is high after a read |
| busy | output | 1 | High during the second cycle of a word access |
| done | output | 1 | One-cycle pulse at the end of an access |

## Verification
For a byte access, `done`, and on a read `rdata`, are due in the cycle right after the edge that accepts the request. For a word access, `busy` is due in that same cycle, and `done` with the full `rdata` one cycle later. The bench drives every request on a falling edge and drops it on the next falling edge. It samples the outputs at that falling edge for a byte access, and again one cycle later for a word access. Cell placement is confirmed by single-byte reads of each cell after word writes.

// File: rtl/bcm_pkg.sv
// Package bcm_pkg
// Shared widths and the phase type for the byte-cell memory.
// Assumes: a word is exactly two cells.
package bcm_pkg;
    localparam int CELL_W = 8;
    localparam int WORD_W = 2 * CELL_W;

    typedef enum logic {
        PH_IDLE   = 1'b0,
        PH_SECOND = 1'b1
    } phase_t;
endpackage

// File: rtl/bcm_sequencer.sv
// Module bcm_sequencer
// Accepts requests and turns each one into one or two single-cell
// operations. It computes the cell address, the write byte and the
// read lane for the operation in each cycle.
// Assumes: requests are ignored while the second phase runs.
module bcm_sequencer
    import bcm_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic              word,
    input  logic              big_end,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [ADDR_W-1:0] cell_addr,
    output logic              cell_we,
    output logic [CELL_W-1:0] cell_wbyte,
    output logic              rd_en,
    output logic              byte_mode,
    output logic              lane_hi,
    output logic              busy,
    output logic              done
);
    phase_t            phase;
    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] wdata_q;
    logic              we_q;
    logic              big_q;
    logic              take;
    logic              active;
    logic              op_we;

    assign take   = (phase == PH_IDLE) && req;
    assign active = take || (phase == PH_SECOND);

    // Choose the cell, byte and lane for the operation in this cycle
    always_comb begin
        if (phase == PH_SECOND) begin
            cell_addr  = addr_q + 1'b1;
            op_we      = we_q;
            lane_hi    = !big_q;
            cell_wbyte = big_q ? wdata_q[CELL_W-1:0] : wdata_q[WORD_W-1:CELL_W];
            byte_mode  = 1'b0;
        end else begin
            cell_addr  = addr;
            op_we      = we;
            lane_hi    = word && big_end;
            cell_wbyte = (word && big_end) ? wdata[WORD_W-1:CELL_W] : wdata[CELL_W-1:0];
            byte_mode  = !word;
        end
    end

    assign cell_we = active && op_we;
    assign rd_en   = active && !op_we;
    assign busy    = (phase == PH_SECOND);

    // Phase register, latched request fields and the completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
            we_q    <= 1'b0;
            big_q   <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= (take && !word) || (phase == PH_SECOND);
            if (take && word) begin
                phase   <= PH_SECOND;
                addr_q  <= addr;
                wdata_q <= wdata;
                we_q    <= we;
                big_q   <= big_end;
            end else begin
                phase <= PH_IDLE;
            end
        end
    end

    // R6
    word_second_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy && done));

    // R6
    done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R7
    second_cell_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cell_addr == ADDR_W'($past(cell_addr) + 1'b1)));

    // R8
    busy_req_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req) |=> !busy);
endmodule

// File: rtl/bcm_cell_array.sv
// Module bcm_cell_array
// Storage of 2**ADDR_W cells of 8 bits. The write is synchronous and the
// read is combinational.
// Assumes: contents are undefined until written; there is no reset.
module bcm_cell_array
    import bcm_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] cell_addr,
    input  logic              cell_we,
    input  logic [CELL_W-1:0] cell_wbyte,
    output logic [CELL_W-1:0] rd_byte
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [CELL_W-1:0] cells [DEPTH];

    // Store one whole byte into the addressed cell
    always_ff @(posedge clk) begin
        if (cell_we) cells[cell_addr] <= cell_wbyte;
    end

    assign rd_byte = cells[cell_addr];

    // R1
    write_lands_chk: assert property (@(posedge clk)
        cell_we |=> (cells[$past(cell_addr)] == $past(cell_wbyte)));
endmodule

// File: rtl/bcm_read_merge.sv
// Module bcm_read_merge
// Builds the registered read result. A byte read fills the low half and
// clears the high half. A word read fills one half per cycle.
// Assumes: the lane is chosen by the sequencer.
module bcm_read_merge
    import bcm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              byte_mode,
    input  logic              lane_hi,
    input  logic [CELL_W-1:0] rd_byte,
    output logic [WORD_W-1:0] rdata
);
    // Capture the byte read in this cycle into its lane of the result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            if (byte_mode)    rdata <= {{CELL_W{1'b0}}, rd_byte};
            else if (lane_hi) rdata[WORD_W-1:CELL_W] <= rd_byte;
            else              rdata[CELL_W-1:0] <= rd_byte;
        end
    end

    // R1
    byte_read_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && byte_mode) |=> (rdata[WORD_W-1:CELL_W] == '0));
endmodule

// File: rtl/byte_cell_mem.sv
// Module byte_cell_mem
// Top level. It wires the sequencer, the cell array and the read merge
// into a byte and word memory with selectable byte order for words.
// Assumes: one access at a time; requests are taken only while idle.
module byte_cell_mem
    import bcm_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic              word,
    input  logic              big_end,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    output logic [15:0]       rdata,
    output logic              busy,
    output logic              done
);
    logic [ADDR_W-1:0] cell_addr;
    logic              cell_we;
    logic [CELL_W-1:0] cell_wbyte;
    logic [CELL_W-1:0] rd_byte;
    logic              rd_en;
    logic              byte_mode;
    logic              lane_hi;

    bcm_sequencer #(.ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .word(word),
        .big_end(big_end), .addr(addr), .wdata(wdata),
        .cell_addr(cell_addr), .cell_we(cell_we), .cell_wbyte(cell_wbyte),
        .rd_en(rd_en), .byte_mode(byte_mode), .lane_hi(lane_hi),
        .busy(busy), .done(done)
    );

    bcm_cell_array #(.ADDR_W(ADDR_W)) u_cells (
        .clk(clk), .cell_addr(cell_addr), .cell_we(cell_we),
        .cell_wbyte(cell_wbyte), .rd_byte(rd_byte)
    );

    bcm_read_merge u_merge (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .byte_mode(byte_mode),
        .lane_hi(lane_hi), .rd_byte(rd_byte), .rdata(rdata)
    );
endmodule

// File: tb/byte_cell_mem_test.sv
module byte_cell_mem_test;
    localparam int AW  = 11;
    localparam int TOP = (1 << AW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0;
    logic          we = 1'b0;
    logic          word = 1'b0;
    logic          big_end = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [15:0]   wdata = '0;
    logic [15:0]   rdata;
    logic          busy;
    logic          done;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    byte_cell_mem #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .word(word),
        .big_end(big_end), .addr(addr), .wdata(wdata),
        .rdata(rdata), .busy(busy), .done(done)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One access with its timing checked; returns rdata once done is high
    task automatic access(input logic w, input logic wd, input logic be,
                          input logic [AW-1:0] a, input logic [15:0] d,
                          output logic [15:0] q);
        @(negedge clk);
        req = 1'b1; we = w; word = wd; big_end = be; addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0;
        if (wd) begin
            check("R6 word busy", {15'b0, busy}, 16'd1);
            check("R6 word early done", {15'b0, done}, 16'd0);
            @(negedge clk);
        end else begin
            check("R6 byte busy", {15'b0, busy}, 16'd0);
        end
        check("R6 done", {15'b0, done}, 16'd1);
        q = rdata;
    endtask

    task automatic t_reset;
        check("R9 done", {15'b0, done}, 16'd0);
        check("R9 busy", {15'b0, busy}, 16'd0);
        check("R9 rdata", rdata, 16'h0000);
    endtask

    task automatic t_byte;
        logic [15:0] q;
        access(1, 0, 0, 11'h010, 16'hFFA5, q);
        access(1, 0, 1, 11'h011, 16'h003C, q);
        access(0, 0, 0, 11'h010, 16'h0, q);
        check("R1 byte read", q, 16'h00A5);
        access(0, 0, 1, 11'h011, 16'h0, q);
        check("R1 byte read big_end ignored", q, 16'h003C);
    endtask

    task automatic t_persist;
        logic [15:0] q;
        access(1, 0, 0, 11'h020, 16'h0011, q);
        access(1, 0, 0, 11'h022, 16'h0033, q);
        access(1, 0, 0, 11'h021, 16'h0022, q);
        access(0, 0, 0, 11'h020, 16'h0, q);
        check("R2 lower neighbour", q, 16'h0011);
        access(0, 0, 0, 11'h022, 16'h0, q);
        check("R2 upper neighbour", q, 16'h0033);
        access(1, 0, 0, 11'h02F, 16'h00EE, q);
        access(1, 1, 0, 11'h02D, 16'h1234, q);
        access(0, 0, 0, 11'h02F, 16'h0, q);
        check("R2 cell after word", q, 16'h00EE);
    endtask

    task automatic t_word_le;
        logic [15:0] q;
        access(1, 1, 0, 11'h2AC, 16'h0F23, q);
        access(0, 0, 0, 11'h2AC, 16'h0, q);
        check("R3 low byte at A", q, 16'h0023);
        access(0, 0, 0, 11'h2AD, 16'h0, q);
        check("R3 high byte at A+1", q, 16'h000F);
        access(0, 1, 0, 11'h2AC, 16'h0, q);
        check("R5 le word read", q, 16'h0F23);
        access(0, 1, 1, 11'h2AC, 16'h0, q);
        check("R5 be read of le data", q, 16'h230F);
    endtask

    task automatic t_word_be;
        logic [15:0] q;
        access(1, 1, 1, 11'h140, 16'hC0DE, q);
        access(0, 0, 0, 11'h140, 16'h0, q);
        check("R4 high byte at A", q, 16'h00C0);
        access(0, 0, 0, 11'h141, 16'h0, q);
        check("R4 low byte at A+1", q, 16'h00DE);
        access(0, 1, 1, 11'h140, 16'h0, q);
        check("R5 be word read", q, 16'hC0DE);
    endtask

    task automatic t_wrap;
        logic [15:0] q;
        access(1, 1, 0, AW'(TOP), 16'hAB5A, q);
        access(0, 0, 0, AW'(TOP), 16'h0, q);
        check("R7 top cell", q, 16'h005A);
        access(0, 0, 0, 11'h000, 16'h0, q);
        check("R7 wrapped cell 0", q, 16'h00AB);
        access(0, 1, 1, AW'(TOP), 16'h0, q);
        check("R7 wrapped be read", q, 16'h5AAB);
    endtask

    task automatic t_busy_ignore;
        logic [15:0] q;
        access(1, 0, 0, 11'h050, 16'h0011, q);
        @(negedge clk);
        req = 1'b1; we = 1'b1; word = 1'b1; big_end = 1'b0; addr = 11'h100; wdata = 16'hBEEF;
        @(negedge clk);
        check("R8 busy", {15'b0, busy}, 16'd1);
        req = 1'b1; we = 1'b1; word = 1'b0; addr = 11'h050; wdata = 16'h0077;
        @(negedge clk);
        req = 1'b0;
        check("R8 done not delayed", {15'b0, done}, 16'd1);
        check("R8 busy ended", {15'b0, busy}, 16'd0);
        access(0, 0, 0, 11'h050, 16'h0, q);
        check("R8 ignored write", q, 16'h0011);
        access(0, 1, 0, 11'h100, 16'h0, q);
        check("R8 word kept", q, 16'hBEEF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_byte();
        t_persist();
        t_word_le();
        t_word_be();
        t_wrap();
        t_busy_ignore();
        repeat (2) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule